// File: doc/BRIEF.md
# GPIO Port with Steerable Interrupts

A bank of general-purpose pins behind a small 32-bit register interface. Each pin can be driven or left as an input. Software sets the value driven onto each pin and a per-pin output-enable. Pin inputs pass through a two-stage synchronizer, and their current values can be read back from a register.

Each pin also has an interrupt source. Two configuration bits per pin pick the trigger: low level, high level, falling edge or rising edge. A mask bit per pin gates the source. A byte-wide steering entry per pin sends the gated source to one of `NIRQ` interrupt outputs, or to none. Pins that are steered to the same output are ORed together.

Each interrupt output is registered. For an edge trigger it gives a single-cycle pulse. For a level trigger it stays high for as long as the level holds.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset, pad_oe and pad_out are all zero and irq_o is zero. The mask, polarity and edge-select words read as zero. Every steering word reads 0xFFFFFFFF.
- R2: A write to 0x04 sets the value on pad_out. A write to 0x08 sets pad_oe, where a 1 enables the driver for that pin. Both registers read back the written value from the cycle after the write.
- R3: Address 0x00 returns the pad inputs after two clock stages of synchronization. A pad change made before a rising edge is visible after the second rising edge, and is not visible after only the first.
- R4: Polarity bit 0 with edge bit 0 (polarity at 0x10, edge at 0x14, bit n for pin n) keeps the steered output high while the synchronized pin is low. The output goes high after the third rising edge that follows the pad change.
- R5: Polarity 1 with edge 0 keeps the steered output high while the pin is high. The output drops three edges after the pin goes low.
- R6: Polarity 0 with edge 1 gives a one-cycle pulse on the steered output. The pulse appears after the third rising edge that follows a falling pad transition.
- R7: Polarity 1 with edge 1 gives a one-cycle pulse in the same way for a rising pad transition.
- R8: A pin whose bit in the mask at 0x0C is clear never asserts any output. The mask reads back its written value.
- R9: Steering entries are bytes, four per word starting at 0x20. Pin 4w+k occupies bits 8k+7:8k of word 0x20+4w. A value of 0xFF steers the pin to no output. Any other value steers it to the output numbered by its low log2(NIRQ) bits.
- R10: When several pins are steered to one output, that output is the OR of their gated sources.
- R11: Writes to unimplemented addresses have no effect, and reads from them return zero. This covers 0x18, 0x1C and the words beyond the steering table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | ADDR_W | Byte address of the register access |
| reg_wen | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| pad_in | input | NLINES | Pin inputs |
| pad_out | output | NLINES | Values driven onto the pins |
| pad_oe | output | NLINES | Per-pin output enable |
| irq_o | output | NIRQ | Interrupt outputs |

## Verification
The bench samples each interrupt exactly on the third edge after a pad change and again one cycle later. A design with a missing or extra pipeline stage would therefore show up immediately, as would an edge trigger that holds high instead of pulsing. Level-low is armed while the pin is high, so a design that inverts polarity would fire early. A masked rising edge, an unrouted active level and two pins sharing one output catch gating that is missing, a 0xFF entry treated as index 3, and sharing implemented as a last-writer-wins mux instead of an OR. Writes to reserved holes and past the table end catch address decoding that aliases onto real registers.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int OFS_DATA = 'h00;
    localparam int OFS_OUT  = 'h04;
    localparam int OFS_DIR  = 'h08;
    localparam int OFS_MASK = 'h0C;
    localparam int OFS_POL  = 'h10;
    localparam int OFS_EDGE = 'h14;
    localparam int OFS_RSVD = 'h18;
    localparam int OFS_MAP  = 'h20;
    localparam logic [7:0] UNROUTED = 8'hFF;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin,
    output logic [W-1:0] cur,
    output logic [W-1:0] last
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
        logic [W-1:0] prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.s1   = pin;
        st_d.s2   = st_q.s1;
        st_d.prev = st_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cur  = st_q.s2;
    assign last = st_q.prev;
endmodule

// File: rtl/gpio_trigger.sv
module gpio_trigger #(
    parameter int W = 32
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] last,
    input  logic [W-1:0] pol,
    input  logic [W-1:0] edg,
    input  logic [W-1:0] mask,
    output logic [W-1:0] fire
);
    for (genvar g = 0; g < W; g++) begin : g_line
        logic hit;
        always_comb begin
            case ({pol[g], edg[g]})
                2'b00:   hit = ~cur[g];
                2'b01:   hit = last[g] & ~cur[g];
                2'b10:   hit = cur[g];
                default: hit = cur[g] & ~last[g];
            endcase
        end
        assign fire[g] = mask[g] & hit;
    end
endmodule

// File: rtl/gpio_route.sv
module gpio_route import gpio_pkg::*; #(
    parameter int NLINES = 32,
    parameter int NIRQ   = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NLINES-1:0]      fire,
    input  logic [NLINES-1:0][7:0] map,
    output logic [NIRQ-1:0]        irq
);
    localparam int IW = (NIRQ > 1) ? $clog2(NIRQ) : 1;

    logic [NIRQ-1:0] irq_d, irq_q;

    always_comb begin
        irq_d = '0;
        for (int j = 0; j < NIRQ; j++) begin
            for (int i = 0; i < NLINES; i++) begin
                if (fire[i] && (map[i] != UNROUTED) && (map[i][IW-1:0] == IW'(j)))
                    irq_d[j] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= '0;
        else        irq_q <= irq_d;
    end

    assign irq = irq_q;
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port import gpio_pkg::*; #(
    parameter int NLINES = 32,
    parameter int NIRQ   = 4,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wen,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [NLINES-1:0] pad_in,
    output logic [NLINES-1:0] pad_out,
    output logic [NLINES-1:0] pad_oe,
    output logic [NIRQ-1:0]   irq_o
);
    localparam int MAP_WORDS = (NLINES + 3) / 4;
    localparam int WA_W      = ADDR_W - 2;
    localparam logic [WA_W-1:0] WA_DATA    = WA_W'(OFS_DATA >> 2);
    localparam logic [WA_W-1:0] WA_OUT     = WA_W'(OFS_OUT  >> 2);
    localparam logic [WA_W-1:0] WA_DIR     = WA_W'(OFS_DIR  >> 2);
    localparam logic [WA_W-1:0] WA_MASK    = WA_W'(OFS_MASK >> 2);
    localparam logic [WA_W-1:0] WA_POL     = WA_W'(OFS_POL  >> 2);
    localparam logic [WA_W-1:0] WA_EDGE    = WA_W'(OFS_EDGE >> 2);
    localparam logic [WA_W-1:0] WA_MAP     = WA_W'(OFS_MAP  >> 2);
    localparam logic [WA_W-1:0] WA_MAP_END = WA_W'((OFS_MAP >> 2) + MAP_WORDS);

    typedef struct packed {
        logic [NLINES-1:0]      dout;
        logic [NLINES-1:0]      dir;
        logic [NLINES-1:0]      mask;
        logic [NLINES-1:0]      pol;
        logic [NLINES-1:0]      edg;
        logic [NLINES-1:0][7:0] map;
    } cfg_t;

    localparam cfg_t CFG_RST = '{dout: '0, dir: '0, mask: '0, pol: '0, edg: '0,
                                 map: {NLINES{UNROUTED}}};

    cfg_t cfg_d, cfg_q;

    logic [WA_W-1:0]   wa;
    logic [WA_W-1:0]   map_rel;
    logic              map_hit;
    logic [NLINES-1:0] line_now;
    logic [NLINES-1:0] line_prev;
    logic [NLINES-1:0] fire;

    assign wa      = reg_addr[ADDR_W-1:2];
    assign map_rel = wa - WA_MAP;
    assign map_hit = (wa >= WA_MAP) && (wa < WA_MAP_END);

    // next-state of the configuration registers
    always_comb begin
        cfg_d = cfg_q;
        if (reg_wen) begin
            if (wa == WA_OUT)  cfg_d.dout = reg_wdata[NLINES-1:0];
            if (wa == WA_DIR)  cfg_d.dir  = reg_wdata[NLINES-1:0];
            if (wa == WA_MASK) cfg_d.mask = reg_wdata[NLINES-1:0];
            if (wa == WA_POL)  cfg_d.pol  = reg_wdata[NLINES-1:0];
            if (wa == WA_EDGE) cfg_d.edg  = reg_wdata[NLINES-1:0];
            if (map_hit) begin
                for (int i = 0; i < NLINES; i++) begin
                    if ((i / 4) == int'(map_rel))
                        cfg_d.map[i] = reg_wdata[8*(i%4) +: 8];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= CFG_RST;
        else        cfg_q <= cfg_d;
    end

    // read path, zero for every unimplemented word
    always_comb begin
        reg_rdata = '0;
        if (wa == WA_DATA) reg_rdata = 32'(line_now);
        if (wa == WA_OUT)  reg_rdata = 32'(cfg_q.dout);
        if (wa == WA_DIR)  reg_rdata = 32'(cfg_q.dir);
        if (wa == WA_MASK) reg_rdata = 32'(cfg_q.mask);
        if (wa == WA_POL)  reg_rdata = 32'(cfg_q.pol);
        if (wa == WA_EDGE) reg_rdata = 32'(cfg_q.edg);
        if (map_hit) begin
            for (int i = 0; i < NLINES; i++) begin
                if ((i / 4) == int'(map_rel))
                    reg_rdata[8*(i%4) +: 8] = cfg_q.map[i];
            end
        end
    end

    assign pad_out = cfg_q.dout;
    assign pad_oe  = cfg_q.dir;

    gpio_sync #(.W(NLINES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .pin  (pad_in),
        .cur  (line_now),
        .last (line_prev)
    );

    gpio_trigger #(.W(NLINES)) u_trig (
        .cur (line_now),
        .last(line_prev),
        .pol (cfg_q.pol),
        .edg (cfg_q.edg),
        .mask(cfg_q.mask),
        .fire(fire)
    );

    gpio_route #(.NLINES(NLINES), .NIRQ(NIRQ)) u_route (
        .clk  (clk),
        .rst_n(rst_n),
        .fire (fire),
        .map  (cfg_q.map),
        .irq  (irq_o)
    );
endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk import gpio_pkg::*; #(
    parameter int NLINES = 32,
    parameter int NIRQ   = 4,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_wen,
    input logic [31:0]       reg_wdata,
    input logic [31:0]       reg_rdata,
    input logic [NLINES-1:0] pad_out,
    input logic [NLINES-1:0] pad_oe,
    input logic [NIRQ-1:0]   irq_o,
    input logic [NLINES-1:0] mask_q
);
    localparam int WA_W = ADDR_W - 2;
    localparam logic [WA_W-1:0] C_OUT  = WA_W'(OFS_OUT  >> 2);
    localparam logic [WA_W-1:0] C_DIR  = WA_W'(OFS_DIR  >> 2);
    localparam logic [WA_W-1:0] C_MASK = WA_W'(OFS_MASK >> 2);
    localparam logic [WA_W-1:0] C_RSVD = WA_W'(OFS_RSVD >> 2);

    assert_dir_drive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wen && reg_addr[ADDR_W-1:2] == C_DIR) |=> pad_oe == $past(reg_wdata[NLINES-1:0]));

    assert_out_drive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wen && reg_addr[ADDR_W-1:2] == C_OUT) |=> pad_out == $past(reg_wdata[NLINES-1:0]));

    assert_mask_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o != '0) |-> ($past(mask_q) != '0));

    assert_mask_readback_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wen && reg_addr[ADDR_W-1:2] == C_MASK) |=>
        (reg_addr[ADDR_W-1:2] != C_MASK || reg_rdata == 32'($past(reg_wdata[NLINES-1:0]))));

    assert_hole_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr[ADDR_W-1:2] == C_RSVD) |-> reg_rdata == 32'h0);
endmodule

bind gpio_irq_port gpio_irq_port_chk #(.NLINES(NLINES), .NIRQ(NIRQ), .ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_addr (reg_addr),
    .reg_wen  (reg_wen),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .pad_out  (pad_out),
    .pad_oe   (pad_oe),
    .irq_o    (irq_o),
    .mask_q   (cfg_q.mask)
);

// File: tb/tb_gpio_irq_port.sv
module tb_gpio_irq_port;
    localparam int NLINES = 32;
    localparam int NIRQ   = 4;
    localparam int ADDR_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic              reg_wen = 1'b0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic [NLINES-1:0] pad_in = '0;
    logic [NLINES-1:0] pad_out;
    logic [NLINES-1:0] pad_oe;
    logic [NIRQ-1:0]   irq_o;

    int n_chk  = 0;
    int n_fail = 0;
    logic [31:0] pol = '0, edg = '0, msk = '0;

    always #5 clk = ~clk;

    gpio_irq_port #(.NLINES(NLINES), .NIRQ(NIRQ), .ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wen(reg_wen),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .irq_o(irq_o)
    );

    typedef struct packed {
        logic        wr;
        logic [7:0]  addr;
        logic [31:0] data;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 8'h08, 32'h0000_0000, 4'd1},   // R1 direction clear
        '{1'b0, 8'h0C, 32'h0000_0000, 4'd1},   // R1 mask clear
        '{1'b0, 8'h10, 32'h0000_0000, 4'd1},   // R1 polarity clear
        '{1'b0, 8'h20, 32'hFFFF_FFFF, 4'd1},   // R1 steering unrouted
        '{1'b0, 8'h3C, 32'hFFFF_FFFF, 4'd1},   // R1 last steering word
        '{1'b1, 8'h04, 32'hA5A5_0F0F, 4'd2},
        '{1'b0, 8'h04, 32'hA5A5_0F0F, 4'd2},   // R2 output readback
        '{1'b1, 8'h08, 32'hFFFF_0000, 4'd2},
        '{1'b0, 8'h08, 32'hFFFF_0000, 4'd2},   // R2 direction readback
        '{1'b1, 8'h0C, 32'h0000_00F0, 4'd8},
        '{1'b0, 8'h0C, 32'h0000_00F0, 4'd8},   // R8 mask readback
        '{1'b1, 8'h18, 32'h1234_5678, 4'd11},
        '{1'b0, 8'h18, 32'h0000_0000, 4'd11},  // R11 reserved hole
        '{1'b1, 8'h40, 32'hDEAD_BEEF, 4'd11},
        '{1'b0, 8'h40, 32'h0000_0000, 4'd11},  // R11 past the table
        '{1'b1, 8'h24, 32'h0302_0100, 4'd9},
        '{1'b0, 8'h24, 32'h0302_0100, 4'd9}    // R9 byte lanes
    };

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_wen   = 1'b1;
        @(negedge clk);
        reg_wen   = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        reg_addr = a;
        #1;
        check(reg_rdata, exp, tag);
    endtask

    task automatic step(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic chk_irq(input logic [NIRQ-1:0] exp, input string tag);
        check(32'(irq_o), 32'(exp), tag);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        step(3);
        rst_n = 1'b1;
        step(1);
        check(32'(pad_oe), 32'h0, "R1 pad_oe after reset");
        check(32'(pad_out), 32'h0, "R1 pad_out after reset");
        chk_irq('0, "R1 irq after reset");

        for (int v = 0; v < NV; v++) begin
            if (VECS[v].wr) wr(VECS[v].addr, VECS[v].data);
            else rd(VECS[v].addr, VECS[v].data, $sformatf("R%0d vector %0d", VECS[v].req, v));
        end
        check(32'(pad_out), 32'hA5A5_0F0F, "R2 pad_out value");
        check(32'(pad_oe), 32'hFFFF_0000, "R2 pad_oe value");
        wr(8'h0C, 32'h0);
        wr(8'h24, 32'hFFFF_FFFF);

        // R3: input synchronizer depth
        pad_in = 32'hC3A5_0F96;
        step(1);
        rd(8'h00, 32'h0, "R3 data not yet visible");
        step(1);
        rd(8'h00, 32'hC3A5_0F96, "R3 data after two stages");
        pad_in = '0;
        step(4);

        // R7: rising edge on pin 0 steered to output 1
        pol = 32'h1; edg = 32'h1; msk = 32'h1;
        wr(8'h10, pol); wr(8'h14, edg); wr(8'h20, 32'hFFFF_FF01); wr(8'h0C, msk);
        pad_in[0] = 1'b1;
        step(2); chk_irq(4'b0000, "R7 no pulse before third edge");
        step(1); chk_irq(4'b0010, "R7 rising pulse");
        step(1); chk_irq(4'b0000, "R7 pulse lasts one cycle");

        // R6: falling edge on pin 0
        pol[0] = 1'b0; wr(8'h10, pol);
        step(3);
        pad_in[0] = 1'b0;
        step(3); chk_irq(4'b0010, "R6 falling pulse");
        step(1); chk_irq(4'b0000, "R6 pulse lasts one cycle");

        // R5: level high on pin 5 steered to output 2
        pol[5] = 1'b1; msk[5] = 1'b1;
        wr(8'h10, pol); wr(8'h24, 32'hFFFF_02FF); wr(8'h0C, msk);
        pad_in[5] = 1'b1;
        step(3); chk_irq(4'b0100, "R5 level high asserted");
        step(3); chk_irq(4'b0100, "R5 level high held");
        pad_in[5] = 1'b0;
        step(2); chk_irq(4'b0100, "R5 still high before third edge");
        step(1); chk_irq(4'b0000, "R5 released");

        // R4: level low on pin 9 steered to output 3
        pad_in[9] = 1'b1;
        step(3);
        msk[9] = 1'b1;
        wr(8'h28, 32'hFFFF_03FF); wr(8'h0C, msk);
        step(2); chk_irq(4'b0000, "R4 idle while pin high");
        pad_in[9] = 1'b0;
        step(3); chk_irq(4'b1000, "R4 level low asserted");
        pad_in[9] = 1'b1;
        step(3); chk_irq(4'b0000, "R4 released");

        // R8: masked rising edge on pin 12 steered to output 0
        pol[12] = 1'b1; edg[12] = 1'b1;
        wr(8'h10, pol); wr(8'h14, edg); wr(8'h2C, 32'hFFFF_FF00);
        pad_in[12] = 1'b1;
        step(3); chk_irq(4'b0000, "R8 masked edge silent");
        step(1); chk_irq(4'b0000, "R8 masked edge silent later");
        msk[12] = 1'b1; wr(8'h0C, msk);
        pad_in[12] = 1'b0;
        step(4);
        pad_in[12] = 1'b1;
        step(3); chk_irq(4'b0001, "R8 unmasked edge fires");
        step(1); chk_irq(4'b0000, "R8 unmasked pulse ends");

        // R9: pin 16 active level but steering entry 0xFF
        pol[16] = 1'b1; msk[16] = 1'b1;
        wr(8'h10, pol); wr(8'h0C, msk);
        pad_in[16] = 1'b1;
        step(3); chk_irq(4'b0000, "R9 unrouted pin silent");
        step(2); chk_irq(4'b0000, "R9 unrouted pin silent later");

        // R10: pins 20 and 21 share output 1
        pol[20] = 1'b1; pol[21] = 1'b1; msk[20] = 1'b1; msk[21] = 1'b1;
        wr(8'h10, pol); wr(8'h34, 32'hFFFF_0101); wr(8'h0C, msk);
        pad_in[20] = 1'b1;
        step(3); chk_irq(4'b0010, "R10 first source");
        pad_in[21] = 1'b1;
        step(3); chk_irq(4'b0010, "R10 both sources");
        pad_in[20] = 1'b0;
        step(3); chk_irq(4'b0010, "R10 second source holds output");
        pad_in[21] = 1'b0;
        step(3); chk_irq(4'b0000, "R10 both released");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule